// File: doc/BRIEF.md
# Link Start-up Handshake Sequencer

This block brings a serial uplink into step with a downlink master before normal traffic flows. It watches a stream of already-decoded downlink symbols, each offered as a 3-bit code with a valid strobe. From that stream it picks which symbol the uplink transmitter sends next and reports when the link is ready for data. Two start-up procedures are supported. The regular one opens with start-of-sync markers and passes through a comma phase, a K28.1 phase and an end-of-sync phase. The quick one goes from K28.1 straight to traffic, with the uplink answering end-of-sync. Symbol decoding, line coding and serialization sit outside the block.

Every phase needs a programmable run of consecutive expected symbols before it advances. A start-of-sync marker seen anywhere restarts the regular procedure. A symbol that does not fit the current phase sends the block back to idle and raises a one-cycle alert. A sticky loss-of-sync flag records that sync was lost or never reached after an error. Once locked, the block lets the uplink send data frames and inserts a K28.5 comma at a fixed period.

Top module: `link_sync_seq`

## Requirements
- R1: While reset is high and after it is released, the block is idle. tx_sym is K28.5 (code 3), and synced, tx_frame_en, alert and bad_sync are all 0.
- R2: In idle, a valid start-of-sync (code 1) enters the start phase, and the uplink sends K28.5 there. After N consecutive start-of-sync symbols the block moves to the K28.1 phase, where the uplink sends K28.1 (code 4).
- R3: In the K28.1 phase, N consecutive K28.1 move the block to the end phase, where the uplink sends end-of-sync (code 2). In the end phase, N consecutive end-of-sync lock the link and set synced.
- R4: In idle, a valid K28.1 starts the quick procedure, and the uplink sends end-of-sync. N consecutive K28.1 in total lock the link.
- R5: While synced, tx_sym is FRAME (code 5) with tx_frame_en high. The exception is every COMMA_PERIOD-th cycle counted from lock, on which tx_sym is K28.5 and tx_frame_en is low. tx_frame_en is never high outside sync.
- R6: A valid start-of-sync in any state other than the start phase restarts the regular procedure and counts as its first symbol. This includes the synced state, which it leaves.
- R7: Outside idle and sync, a valid symbol other than the phase's expected one returns the block to idle. This includes codes 0, 6 and 7. alert then pulses high for exactly one cycle.
- R8: bad_sync is set by every mismatch and by a start-of-sync that ends sync. It is cleared when the link locks and holds its value otherwise.
- R9: N equals run_len, except that run_len 0 selects DEFAULT_RUN (4). With N = 1, every phase advances on its first expected symbol.
- R10: In idle, valid symbols other than start-of-sync and K28.1 are ignored. A cycle with rx_valid low never changes the state or the run count.
- R11: While synced, K28.5, FRAME and end-of-sync are accepted. Any other code except start-of-sync is a mismatch, with the same effect as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | rx_sym carries a decoded downlink symbol this cycle |
| rx_sym | input | 3 | Downlink symbol code: 1 start-of-sync, 2 end-of-sync, 3 K28.5, 4 K28.1, 5 frame |
| run_len | input | CNT_W (4) | Run length N per phase; 0 selects DEFAULT_RUN |
| tx_sym | output | 3 | Symbol the uplink sends this cycle, same coding as rx_sym |
| tx_frame_en | output | 1 | Uplink may send a data frame this cycle |
| synced | output | 1 | Link locked |
| alert | output | 1 | One-cycle pulse on a sequence mismatch |
| bad_sync | output | 1 | Sticky loss-of-sync flag |

## Verification
Every output is due one rising edge after the symbol that causes it. The state, the alert pulse and the loss-of-sync flag are all registered on the same edge that consumes the symbol. The comma slot depends only on the number of edges since lock, so it falls on the COMMA_PERIOD-th sync cycle. The bench changes inputs on the falling edge and updates its reference model on the rising edge. At the next falling edge, before it drives the next symbol, it compares all five outputs with the model.

// File: rtl/link_sync_pkg.sv
package link_sync_pkg;

    typedef enum logic [2:0] {
        SYM_NONE  = 3'd0,
        SYM_SOS   = 3'd1,
        SYM_EOS   = 3'd2,
        SYM_K285  = 3'd3,
        SYM_K281  = 3'd4,
        SYM_FRAME = 3'd5
    } lsync_sym_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOS,
        ST_K281,
        ST_EOS,
        ST_QUICK,
        ST_SYNC
    } lsync_state_e;

    typedef struct packed {
        logic mismatch;
        logic drop;
        logic lock;
    } lsync_ev_t;

    // symbol a counting phase waits for
    function automatic logic [2:0] phase_expect(lsync_state_e s);
        case (s)
            ST_SOS:            return SYM_SOS;
            ST_K281, ST_QUICK: return SYM_K281;
            ST_EOS:            return SYM_EOS;
            default:           return SYM_NONE;
        endcase
    endfunction

    // phase that follows a completed run
    function automatic lsync_state_e phase_next(lsync_state_e s);
        case (s)
            ST_SOS:           return ST_K281;
            ST_K281:          return ST_EOS;
            ST_EOS, ST_QUICK: return ST_SYNC;
            default:          return ST_IDLE;
        endcase
    endfunction

    function automatic logic sync_accepts(logic [2:0] sym);
        return (sym == SYM_K285) || (sym == SYM_FRAME) || (sym == SYM_EOS);
    endfunction

    // uplink symbol chosen from state and comma slot
    function automatic logic [2:0] tx_for(lsync_state_e s, logic comma_slot);
        case (s)
            ST_K281:          return SYM_K281;
            ST_EOS, ST_QUICK: return SYM_EOS;
            ST_SYNC:          return comma_slot ? SYM_K285 : SYM_FRAME;
            default:          return SYM_K285;
        endcase
    endfunction

endpackage

// File: rtl/link_sync_fsm.sv
module link_sync_fsm
    import link_sync_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int DEFAULT_RUN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [2:0]         rx_sym,
    input  logic [CNT_W-1:0]   run_len,
    output lsync_state_e       state,
    output lsync_ev_t          ev
);

    localparam int NW = CNT_W + 1;

    logic [CNT_W-1:0] cnt, cnt_n;
    lsync_state_e     st_n;
    logic [NW-1:0]    need;
    logic [NW-1:0]    cnt_inc;
    logic             run_done;
    logic             one_run;

    assign need     = (run_len == '0) ? NW'(DEFAULT_RUN) : {1'b0, run_len};
    assign cnt_inc  = {1'b0, cnt} + NW'(1);
    assign run_done = (cnt_inc >= need);
    assign one_run  = (need <= NW'(1));

    always_comb begin
        st_n = state;
        cnt_n = cnt;
        ev = '0;
        if (rx_valid) begin
            if (rx_sym == SYM_SOS && state != ST_SOS) begin
                // restart regular procedure, this marker is the first of the run
                ev.drop = (state == ST_SYNC);
                if (one_run) begin
                    st_n = ST_K281;
                    cnt_n = '0;
                end else begin
                    st_n = ST_SOS;
                    cnt_n = CNT_W'(1);
                end
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (rx_sym == SYM_K281) begin
                            cnt_n = '0;
                            if (run_done) begin
                                st_n = ST_SYNC;
                                ev.lock = 1'b1;
                            end else begin
                                st_n = ST_QUICK;
                                cnt_n = cnt_inc[CNT_W-1:0];
                            end
                        end
                    end
                    ST_SYNC: begin
                        if (!sync_accepts(rx_sym)) begin
                            st_n = ST_IDLE;
                            cnt_n = '0;
                            ev.mismatch = 1'b1;
                        end
                    end
                    default: begin
                        if (rx_sym == phase_expect(state)) begin
                            if (run_done) begin
                                st_n = phase_next(state);
                                cnt_n = '0;
                                ev.lock = (phase_next(state) == ST_SYNC);
                            end else begin
                                cnt_n = cnt_inc[CNT_W-1:0];
                            end
                        end else begin
                            st_n = ST_IDLE;
                            cnt_n = '0;
                            ev.mismatch = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= st_n;
            cnt   <= cnt_n;
        end
    end

endmodule

// File: rtl/link_sync_comma.sv
module link_sync_comma
    import link_sync_pkg::*;
#(
    parameter int COMMA_PERIOD = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  lsync_state_e state,
    output logic [2:0]   tx_sym,
    output logic         tx_frame_en
);

    localparam int PW = (COMMA_PERIOD > 2) ? $clog2(COMMA_PERIOD) : 1;
    localparam logic [PW-1:0] LAST = PW'(COMMA_PERIOD - 1);

    logic [PW-1:0] slot;
    logic          in_sync;
    logic          comma_slot;

    assign in_sync    = (state == ST_SYNC);
    assign comma_slot = in_sync && (slot == LAST);

    always_ff @(posedge clk) begin
        if (rst || !in_sync) begin
            slot <= '0;
        end else if (slot == LAST) begin
            slot <= '0;
        end else begin
            slot <= slot + PW'(1);
        end
    end

    assign tx_sym      = tx_for(state, comma_slot);
    assign tx_frame_en = in_sync && !comma_slot;

endmodule

// File: rtl/link_sync_status.sv
module link_sync_status
    import link_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lsync_ev_t ev,
    output logic      alert,
    output logic      bad_sync
);

    always_ff @(posedge clk) begin
        if (rst) begin
            alert    <= 1'b0;
            bad_sync <= 1'b0;
        end else begin
            alert <= ev.mismatch;
            if (ev.mismatch || ev.drop) begin
                bad_sync <= 1'b1;
            end else if (ev.lock) begin
                bad_sync <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/link_sync_seq.sv
module link_sync_seq
    import link_sync_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter int DEFAULT_RUN  = 4,
    parameter int COMMA_PERIOD = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [2:0]       rx_sym,
    input  logic [CNT_W-1:0] run_len,
    output logic [2:0]       tx_sym,
    output logic             tx_frame_en,
    output logic             synced,
    output logic             alert,
    output logic             bad_sync
);

    lsync_state_e state;
    lsync_ev_t    ev;

    link_sync_fsm #(
        .CNT_W       (CNT_W),
        .DEFAULT_RUN (DEFAULT_RUN)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_sym   (rx_sym),
        .run_len  (run_len),
        .state    (state),
        .ev       (ev)
    );

    link_sync_comma #(
        .COMMA_PERIOD (COMMA_PERIOD)
    ) u_comma (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .tx_sym      (tx_sym),
        .tx_frame_en (tx_frame_en)
    );

    link_sync_status u_status (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .alert    (alert),
        .bad_sync (bad_sync)
    );

    assign synced = (state == ST_SYNC);

endmodule

// File: rtl/link_sync_seq_chk.sv
module link_sync_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic [2:0] rx_sym,
    input logic [2:0] tx_sym,
    input logic       tx_frame_en,
    input logic       synced,
    input logic       alert,
    input logic       bad_sync
);

    AST_ALERT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        alert |=> !alert); // R7

    AST_ALERT_IDLES: assert property (@(posedge clk) disable iff (rst)
        alert |-> (!synced && !tx_frame_en && tx_sym == 3'd3)); // R7

    AST_LOCK_CLEARS_BAD: assert property (@(posedge clk) disable iff (rst)
        $rose(synced) |-> !bad_sync); // R8

    AST_BAD_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(bad_sync) |-> (alert || $past(synced))); // R8

    AST_FRAME_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
        tx_frame_en |-> synced); // R5

    AST_FRAME_SYM_MATCH: assert property (@(posedge clk) disable iff (rst)
        synced |-> (tx_frame_en == (tx_sym == 3'd5))); // R5

    AST_SOS_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sym == 3'd1) |=> !synced); // R6

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && !synced) |=> ($stable(tx_sym) && !synced && !alert)); // R10

endmodule

bind link_sync_seq link_sync_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .rx_sym      (rx_sym),
    .tx_sym      (tx_sym),
    .tx_frame_en (tx_frame_en),
    .synced      (synced),
    .alert       (alert),
    .bad_sync    (bad_sync)
);

// File: tb/tb_link_sync_seq.sv
module tb_link_sync_seq;

    localparam int CLK_PERIOD = 10;
    localparam int COMMA_P    = 16;
    localparam int CNT_W      = 4;
    localparam int DEF_RUN    = 4;
    localparam int WATCHDOG   = 5000;

    localparam logic [2:0] C_NONE  = 3'd0;
    localparam logic [2:0] C_SOS   = 3'd1;
    localparam logic [2:0] C_EOS   = 3'd2;
    localparam logic [2:0] C_K285  = 3'd3;
    localparam logic [2:0] C_K281  = 3'd4;
    localparam logic [2:0] C_FRAME = 3'd5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_valid = 1'b0;
    logic [2:0]       rx_sym = 3'd0;
    logic [CNT_W-1:0] run_len = '0;
    logic [2:0]       tx_sym;
    logic             tx_frame_en;
    logic             synced;
    logic             alert;
    logic             bad_sync;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    string cur_req = "R1";

    // reference model state: 0 idle, 1 start, 2 k28.1, 3 end, 4 quick, 5 sync
    int m_st = 0, m_cnt = 0, m_comma = 0, m_alert = 0, m_bad = 0;
    int trace[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    link_sync_seq #(
        .CNT_W        (CNT_W),
        .DEFAULT_RUN  (DEF_RUN),
        .COMMA_PERIOD (COMMA_P)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_valid),
        .rx_sym      (rx_sym),
        .run_len     (run_len),
        .tx_sym      (tx_sym),
        .tx_frame_en (tx_frame_en),
        .synced      (synced),
        .alert       (alert),
        .bad_sync    (bad_sync)
    );

    function automatic int want_sym(int st);
        if (st == 1) return 1;
        if (st == 3) return 2;
        if (st == 2 || st == 4) return 4;
        return -1;
    endfunction

    function automatic int after(int st);
        if (st == 1) return 2;
        if (st == 2) return 3;
        return 5;
    endfunction

    always @(posedge clk) begin : model
        int need, prev, s;
        bit bad_in;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_comma = 0; m_alert = 0; m_bad = 0;
        end else begin
            need   = (run_len == 0) ? DEF_RUN : int'(run_len);
            prev   = m_st;
            s      = int'(rx_sym);
            m_alert = 0;
            bad_in = 0;
            if (rx_valid) begin
                if (s == 1 && m_st != 1) begin
                    if (m_st == 5) m_bad = 1;
                    if (need == 1) begin m_st = 2; m_cnt = 0; end
                    else begin m_st = 1; m_cnt = 1; end
                end else if (m_st == 0) begin
                    if (s == 4) begin
                        if (need == 1) begin m_st = 5; m_cnt = 0; end
                        else begin m_st = 4; m_cnt = 1; end
                    end
                end else if (m_st == 5) begin
                    if (!(s == 3 || s == 5 || s == 2)) bad_in = 1;
                end else if (s == want_sym(m_st)) begin
                    if (m_cnt + 1 >= need) begin m_st = after(m_st); m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    bad_in = 1;
                end
            end
            if (bad_in) begin
                m_st = 0; m_cnt = 0; m_alert = 1; m_bad = 1;
            end
            if (m_st == 5) begin
                if (prev == 5) m_comma = (m_comma + 1) % COMMA_P;
                else begin m_comma = 0; m_bad = 0; end
            end
            trace.push_back(m_st);
        end
    end

    task automatic compare();
        int e_sym, e_fen, e_syn;
        case (m_st)
            2: e_sym = 4;
            3, 4: e_sym = 2;
            5: e_sym = (m_comma == COMMA_P - 1) ? 3 : 5;
            default: e_sym = 3;
        endcase
        e_syn = (m_st == 5) ? 1 : 0;
        e_fen = (m_st == 5 && e_sym == 5) ? 1 : 0;
        checks++;
        if (int'(tx_sym) != e_sym || int'(tx_frame_en) != e_fen || int'(synced) != e_syn ||
            int'(alert) != m_alert || int'(bad_sync) != m_bad) begin
            fails++;
            $display("FAIL %s t=%0t tx_sym=%0d/%0d frame_en=%0d/%0d synced=%0d/%0d alert=%0d/%0d bad_sync=%0d/%0d (actual/expected)",
                     cur_req, $time, tx_sym, e_sym, tx_frame_en, e_fen, synced, e_syn,
                     alert, m_alert, bad_sync, m_bad);
        end
    endtask

    // compare the result of the last edge, then drive the next symbol
    task automatic cycle(input logic v, input logic [2:0] s);
        @(negedge clk);
        compare();
        rx_valid = v;
        rx_sym   = s;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired after %0d cycles (actual running, expected finished)", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) cycle(1'b0, C_NONE);
        rst = 1'b0;
        cur_req = "R1";
        repeat (3) cycle(1'b0, C_NONE);

        // regular procedure, default run length
        cur_req = "R2 R9";
        repeat (4) cycle(1'b1, C_SOS);
        cur_req = "R3";
        repeat (4) cycle(1'b1, C_K281);
        repeat (4) cycle(1'b1, C_EOS);
        cur_req = "R5 R11";
        for (int i = 0; i < 20; i++) cycle(1'b1, (i % 3 == 0) ? C_K285 : ((i % 7 == 0) ? C_EOS : C_FRAME));
        cycle(1'b0, C_NONE);

        // K28.1 while locked
        cur_req = "R7 R11";
        cycle(1'b1, C_K281);
        repeat (2) cycle(1'b0, C_NONE);

        // idle ignores noise and invalid cycles
        cur_req = "R10";
        cycle(1'b1, C_K285);
        cycle(1'b1, C_FRAME);
        cycle(1'b1, C_EOS);
        cycle(1'b1, 3'd7);
        cycle(1'b0, C_K281);
        cycle(1'b0, C_SOS);

        // quick procedure, run length 2, gap inside the run
        run_len = 4'd2;
        cur_req = "R4 R9 R8";
        cycle(1'b1, C_K281);
        cycle(1'b0, C_NONE);
        cycle(1'b1, C_K281);
        repeat (3) cycle(1'b1, C_FRAME);

        // start-of-sync drops lock and restarts
        cur_req = "R6 R8";
        cycle(1'b1, C_SOS);
        cycle(1'b1, C_SOS);
        cycle(1'b1, C_SOS);
        cycle(1'b1, C_SOS);
        cur_req = "R7";
        cycle(1'b1, C_K285);
        cycle(1'b0, C_NONE);

        // single-symbol runs
        run_len = 4'd1;
        cur_req = "R9";
        cycle(1'b1, C_SOS);
        cycle(1'b1, C_K281);
        cycle(1'b1, C_EOS);
        cycle(1'b1, C_FRAME);
        cur_req = "R11 R4";
        cycle(1'b1, C_K281);
        cycle(1'b1, C_K281);
        cycle(1'b0, C_NONE);

        // reserved and empty codes mid-procedure
        run_len = 4'd3;
        cur_req = "R6 R7";
        cycle(1'b1, C_SOS);
        cycle(1'b1, 3'd6);
        cycle(1'b1, C_K281);
        cycle(1'b1, C_NONE);
        repeat (2) cycle(1'b0, C_NONE);

        // restart inside the K28.1 phase
        cur_req = "R6";
        repeat (3) cycle(1'b1, C_SOS);
        cycle(1'b1, C_K281);
        repeat (3) cycle(1'b1, C_SOS);
        repeat (3) cycle(1'b1, C_K281);
        repeat (3) cycle(1'b1, C_EOS);

        // long lock, two comma slots
        run_len = 4'd0;
        cur_req = "R5";
        repeat (40) cycle(1'b0, C_NONE);
        cycle(1'b0, C_NONE);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule